// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave with Auto-Increment

This block sits on the far side of a slow host link where one byte-wide bus carries both addresses and data. Three active-high strobes, address latch, read and write, bear no relationship to the local clock. The block samples each strobe through a synchronizer chain in its own clock domain and finds its rising and falling edges there. No strobe is ever used as a clock.

A rising address-latch strobe loads the bus byte into the current address. A rising write strobe stores the bus byte into an internal register array at that address. While the synchronized read strobe is high, the block enables its bus driver and presents the addressed register. When a read or write strobe falls, the address steps forward by a fixed increment, wrapping around the array. This lets a host stream a block of bytes after a single address phase.

The pad-level tristate is left to the chip. The block provides the output byte and a separate enable.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset the current address is 0, every register in the array holds 0, `bus_oe` is low and `bus_o` is 0.
- R2: A synchronized rising edge of `ale_i` loads the low ADDR_W = log2(NUM_REGS) bits of `bus_i` into the current address. Higher bus bits are ignored, so with 8 registers, 0x1D selects register 5.
- R3: A synchronized rising edge of `wr_i` stores `bus_i` into the register at the current address. Changes on `bus_i` later in the same write strobe have no effect.
- R4: A synchronized falling edge of `rd_i` or `wr_i` advances the current address by ADDR_INC, modulo NUM_REGS. Without a strobe edge the address holds.
- R5: While the synchronized `rd_i` is high, `bus_oe` is high and `bus_o` shows the register at the current address. At all other times `bus_oe` is low and `bus_o` is 0.
- R6: Each strobe passes through SYNC_STAGES flops before it acts, so `bus_oe` rises exactly SYNC_STAGES clock edges after `rd_i` is first sampled high.
- R7: When an `ale_i` rising edge and a `rd_i` or `wr_i` falling edge fall in the same cycle, the address load wins and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_i | input | 1 | Address latch strobe, asynchronous, active high |
| rd_i | input | 1 | Read strobe, asynchronous, active high |
| wr_i | input | 1 | Write strobe, asynchronous, active high |
| bus_i | input | DATA_W | Byte sampled from the shared bus |
| bus_o | output | DATA_W | Byte to drive onto the shared bus |
| bus_oe | output | 1 | Enable for the bus driver |

## Verification
The bench builds the block with NUM_REGS = 8, ADDR_INC = 1 and SYNC_STAGES = 2. The small array means a three-byte burst from address 6 wraps through 7 to 0. It also means an address byte of 0x1D exercises the discarded upper bits. The strobes are held for many clock cycles, as a slow host would hold them. One test lowers the write strobe and raises the address-latch strobe on the same clock, which forces a load and an increment into one synchronized cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    // Decoded view of one synchronized strobe
    typedef struct packed {
        logic level;   // synchronized strobe level
        logic rise;    // single-cycle rising edge
        logic fall;    // single-cycle falling edge
    } strobe_ev_t;

    // Slot of each strobe inside the strobe vector
    localparam int STB_ALE = 0;
    localparam int STB_RD  = 1;
    localparam int STB_WR  = 2;
    localparam int STB_NUM = 3;

    // Address update chosen this cycle
    typedef enum logic [1:0] {
        ADDR_KEEP = 2'd0,
        ADDR_LOAD = 2'd1,
        ADDR_STEP = 2'd2
    } addr_op_e;

    function automatic addr_op_e pick_addr_op(input strobe_ev_t ale,
                                              input strobe_ev_t rd,
                                              input strobe_ev_t wr);
        if (ale.rise)
            return ADDR_LOAD;
        else if (rd.fall || wr.fall)
            return ADDR_STEP;
        else
            return ADDR_KEEP;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import mbs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_i,
    output strobe_ev_t ev_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= strobe_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], strobe_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    always_comb begin
        ev_o.level = chain_q[STAGES-1];
        ev_o.rise  = chain_q[STAGES-1] & ~last_q;
        ev_o.fall  = ~chain_q[STAGES-1] & last_q;
    end
endmodule

// File: rtl/addr_ctrl.sv
module addr_ctrl
    import mbs_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int ADDR_INC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_ev_t        ale_ev,
    input  strobe_ev_t        rd_ev,
    input  strobe_ev_t        wr_ev,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_INC);

    addr_op_e op;

    always_comb op = pick_addr_op(ale_ev, rd_ev, wr_ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
        end else begin
            unique case (op)
                ADDR_LOAD: addr_o <= load_val;
                ADDR_STEP: addr_o <= addr_o + STEP;
                default:   addr_o <= addr_o;
            endcase
        end
    end
endmodule

// File: rtl/reg_array.sv
module reg_array #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
    import mbs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int NUM_REGS    = 16,
    parameter int ADDR_INC    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe
);
    localparam int ADDR_W = $clog2(NUM_REGS);

    logic [STB_NUM-1:0] raw_stb;
    strobe_ev_t         evs [STB_NUM];
    strobe_ev_t         ale_ev, rd_ev, wr_ev;
    logic [ADDR_W-1:0]  cur_addr;
    logic [DATA_W-1:0]  rd_data;

    always_comb begin
        raw_stb          = '0;
        raw_stb[STB_ALE] = ale_i;
        raw_stb[STB_RD]  = rd_i;
        raw_stb[STB_WR]  = wr_i;
    end

    genvar gi;
    generate
        for (gi = 0; gi < STB_NUM; gi++) begin : g_sync
            strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst      (rst),
                .strobe_i (raw_stb[gi]),
                .ev_o     (evs[gi])
            );
        end
    endgenerate

    assign ale_ev = evs[STB_ALE];
    assign rd_ev  = evs[STB_RD];
    assign wr_ev  = evs[STB_WR];

    addr_ctrl #(.ADDR_W(ADDR_W), .ADDR_INC(ADDR_INC)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .ale_ev   (ale_ev),
        .rd_ev    (rd_ev),
        .wr_ev    (wr_ev),
        .load_val (bus_i[ADDR_W-1:0]),
        .addr_o   (cur_addr)
    );

    reg_array #(.DATA_W(DATA_W), .DEPTH(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ev.rise),
        .addr  (cur_addr),
        .wdata (bus_i),
        .rdata (rd_data)
    );

    assign bus_oe = rd_ev.level;
    assign bus_o  = rd_ev.level ? rd_data : '0;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker
    import mbs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int ADDR_INC    = 1,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_i,
    input logic [ADDR_W-1:0] bus_lo,
    input logic [DATA_W-1:0] bus_o,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] addr,
    input strobe_ev_t        ale_ev,
    input strobe_ev_t        rd_ev,
    input strobe_ev_t        wr_ev
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_INC);

    // R2: address latch loads the low bus bits
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        ale_ev.rise |=> addr == $past(bus_lo));

    // R7: load wins over a same-cycle strobe end
    a_r7_priority: assert property (@(posedge clk) disable iff (rst)
        (ale_ev.rise && (rd_ev.fall || wr_ev.fall)) |=> addr == $past(bus_lo));

    // R4: strobe end steps the address
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (!ale_ev.rise && (rd_ev.fall || wr_ev.fall)) |=> addr == $past(addr) + STEP);

    // R4: address holds with no edge
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!ale_ev.rise && !rd_ev.fall && !wr_ev.fall) |=> $stable(addr));

    // R5: idle bus output is zero
    a_r5_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> bus_o == '0);

    // R6: driver enable lags the raw read strobe by the synchronizer depth
    a_r6_oe_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(rd_i, SYNC_STAGES));
endmodule

bind mux_bus_slave mbs_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_INC(ADDR_INC), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (rd_i),
    .bus_lo (bus_i[ADDR_W-1:0]),
    .bus_o  (bus_o),
    .bus_oe (bus_oe),
    .addr   (cur_addr),
    .ale_ev (ale_ev),
    .rd_ev  (rd_ev),
    .wr_ev  (wr_ev)
);

// File: tb/sim_mux_bus_slave.sv
module sim_mux_bus_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
    logic [7:0] bus_i = 8'h00;
    logic [7:0] bus_o;
    logic       bus_oe;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_slave #(.DATA_W(8), .NUM_REGS(8), .ADDR_INC(1), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .ale_i(ale_i), .rd_i(rd_i), .wr_i(wr_i),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_addr(input logic [7:0] a);
        bus_i = a; wait_n(HOLD);
        ale_i = 1'b1; wait_n(HOLD);
        ale_i = 1'b0; wait_n(HOLD);
    endtask

    task automatic host_write(input logic [7:0] d);
        bus_i = d; wait_n(HOLD);
        wr_i = 1'b1; wait_n(HOLD);
        check("R5 oe low during write", {7'd0, bus_oe}, 8'h00);
        wr_i = 1'b0; wait_n(HOLD);
    endtask

    task automatic host_read(input string req, input logic [7:0] exp);
        bus_i = 8'h00; wait_n(2);
        rd_i = 1'b1; wait_n(HOLD);
        check("R5 oe high during read", {7'd0, bus_oe}, 8'h01);
        check(req, bus_o, exp);
        rd_i = 1'b0; wait_n(HOLD);
        check("R5 oe low after read", {7'd0, bus_oe}, 8'h00);
        check("R5 bus_o zero after read", bus_o, 8'h00);
    endtask

    // R1
    task automatic t_reset();
        check("R1 oe after reset", {7'd0, bus_oe}, 8'h00);
        check("R1 bus_o after reset", bus_o, 8'h00);
        for (int i = 0; i < 8; i++) host_read("R1 array cleared", 8'h00);
    endtask

    // R2 R3 R4 R5
    task automatic t_burst();
        host_addr(8'h02);
        host_write(8'hA1); host_write(8'hB2); host_write(8'hC3);
        host_addr(8'h02);
        host_read("R3 R4 burst reg2", 8'hA1);
        host_read("R4 burst reg3", 8'hB2);
        host_read("R4 burst reg4", 8'hC3);
    endtask

    // R4 wrap
    task automatic t_wrap();
        host_addr(8'h06);
        host_write(8'h11); host_write(8'h22); host_write(8'h33);
        host_addr(8'h06);
        host_read("R4 wrap reg6", 8'h11);
        host_read("R4 wrap reg7", 8'h22);
        host_read("R4 wrap reg0", 8'h33);
    endtask

    // R2 upper bits ignored
    task automatic t_upper_bits();
        host_addr(8'h1D);
        host_write(8'h5A);
        host_addr(8'h05);
        host_read("R2 upper address bits ignored", 8'h5A);
    endtask

    // R7 and R3 late bus change
    task automatic t_priority();
        host_addr(8'h01);
        host_write(8'h10); host_write(8'h20);
        host_addr(8'h04);
        bus_i = 8'h99; wait_n(HOLD);
        wr_i = 1'b1; wait_n(HOLD);
        bus_i = 8'h01; wait_n(2);
        wr_i = 1'b0; ale_i = 1'b1; wait_n(HOLD);
        ale_i = 1'b0; wait_n(HOLD);
        host_read("R7 load wins, reg1", 8'h10);
        host_read("R7 then reg2", 8'h20);
        host_addr(8'h04);
        host_read("R3 late bus change ignored", 8'h99);
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        t_reset();
        t_burst();
        t_wrap();
        t_upper_bits();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule